// File: doc/BRIEF.md
# Receive Byte Counter and Acknowledge Selector

This block sits beside the bit-level engine of a two-wire serial bus controller. It tracks how many data bytes remain in a packet and picks the acknowledge bit to send after each received byte. The bit engine reports three kinds of event: a matched address, a completed byte (with its value), and the end of the transfer on a stop or repeated start. For each address or counted byte, the block returns one registered acknowledge decision with a one-cycle valid strobe.

Software supplies two acknowledge settings. One applies to ordinary data and the other to the byte that exhausts the count. Both are sampled in the event cycle. Any active error flag overrides them with a negative acknowledge. Optionally, the first byte after the address is taken as the packet length and loaded into the counter, without being counted as data. The counter can also be written directly, but only while the block is idle or the bus is being held.

Top module: `bcack_ctrl`

## Requirements
- R1: One cycle after `addr_match_i`, `ack_vld_o` pulses for one cycle and `ack_o` equals `data_nack_i` (0 = ACK, 1 = NACK). The block then enters the load phase if `autoload_en_i` is 1, otherwise the data phase.
- R2: A byte received in the data phase that leaves the count above zero is answered, one cycle later, with `ack_o` equal to `data_nack_i`.
- R3: A byte received in the data phase is answered with `ack_o` equal to `eoc_nack_i` (0 = ACK, 1 = NACK) when the count is 1 (it reaches zero) or is already 0.
- R4: If any bit of `err_flags_i` is 1 in the event cycle, `ack_o` is 1 (NACK), whatever the two settings are.
- R5: In the load phase, the received byte is written into the counter. It is not decremented, it is answered with `data_nack_i`, and the block moves to the data phase.
- R6: An address match never changes `cnt_o`.
- R7: `ack_o` holds its value between events. A change of a setting after the event cycle does not alter the answer already given.
- R8: Each data-phase byte lowers the count by exactly one. At zero the count stays at zero. Without a byte or an accepted write, `cnt_o` does not change.
- R9: `eop_o` is high for exactly one cycle after a data-phase byte takes the count from 1 to 0. A load or a write never raises it.
- R10: `cnt_wr_i` loads `cnt_wdata_i` only when the block is idle or `hold_i` is 1, and only when no counted or loaded byte arrives in the same cycle. Otherwise the write is ignored.
- R11: `xfer_end_i` returns the block to idle. In idle, `byte_rx_i` produces no acknowledge and leaves the count unchanged.
- R12: After reset, `cnt_o` is 0, `cnt_zero_o` is 1, `ack_o` is 1, and `ack_vld_o` and `eop_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_match_i | input | 1 | Address matched strobe |
| byte_rx_i | input | 1 | Byte received strobe |
| byte_data_i | input | DATA_W | Received byte value |
| xfer_end_i | input | 1 | Stop or repeated start seen |
| hold_i | input | 1 | Bus clock is being held |
| data_nack_i | input | 1 | Data acknowledge setting |
| eoc_nack_i | input | 1 | End-of-count acknowledge setting |
| autoload_en_i | input | 1 | First byte after address loads the count |
| cnt_wr_i | input | 1 | Direct count write strobe |
| cnt_wdata_i | input | CNT_W | Direct count write value |
| err_flags_i | input | ERR_W | Error and fault flags |
| ack_o | output | 1 | Acknowledge bit to drive (1 = NACK) |
| ack_vld_o | output | 1 | Acknowledge decision valid pulse |
| cnt_zero_o | output | 1 | Count is zero |
| cnt_o | output | CNT_W | Current byte count |
| eop_o | output | 1 | End-of-packet pulse |

## Verification
The assertions assume that the bit engine never raises `addr_match_i` and `byte_rx_i` together, and that strobes come one cycle at a time. The end-of-count check also relies on a write never coinciding with a byte that empties the counter. The stimulus drives each event as a single-cycle strobe with idle cycles between events, and issues writes only in cycles without a byte.

// File: rtl/bcack_pkg.sv
package bcack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DATA = 2'd2
  } bc_state_e;

endpackage

// File: rtl/bcack_seq.sv
module bcack_seq
  import bcack_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      addr_match_i,
  input  logic      byte_rx_i,
  input  logic      xfer_end_i,
  input  logic      autoload_en_i,
  output bc_state_e state_o,
  output logic      load_ev_o,
  output logic      data_ev_o,
  output logic      addr_ev_o
);

  bc_state_e state_q;
  bc_state_e state_d;

  // event classification from the current phase
  always_comb begin
    addr_ev_o = addr_match_i;
    load_ev_o = byte_rx_i && !addr_match_i && (state_q == ST_LOAD);
    data_ev_o = byte_rx_i && !addr_match_i && (state_q == ST_DATA);
  end

  always_comb begin
    state_d = state_q;
    if (xfer_end_i) begin
      state_d = ST_IDLE;
    end else if (addr_match_i) begin
      state_d = autoload_en_i ? ST_LOAD : ST_DATA;
    end else if (load_ev_o) begin
      state_d = ST_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/bcack_counter.sv
module bcack_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             wr_i,
  input  logic             wr_ok_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             at_end_o,
  output logic             eop_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             eop_q;
  logic             eop_d;
  logic             is_zero;

  assign is_zero = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (dec_i) begin
      if (!is_zero) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - CNT_ONE;
      end
    end else if (wr_i && wr_ok_i) begin
      cnt_en = 1'b1;
      cnt_d  = wr_val_i;
    end
  end

  assign eop_d = dec_i && !load_i && (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop_q <= 1'b0;
    end else begin
      eop_q <= eop_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign zero_o   = is_zero;
  assign at_end_o = is_zero || (cnt_q == CNT_ONE);
  assign eop_o    = eop_q;

endmodule

// File: rtl/bcack_ack_sel.sv
module bcack_ack_sel #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             use_eoc_i,
  input  logic             data_nack_i,
  input  logic             eoc_nack_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             ack_o,
  output logic             vld_o
);

  logic ack_q;
  logic ack_d;
  logic vld_q;
  logic fault;
  logic pick;

  assign fault = |err_i;
  assign pick  = use_eoc_i ? eoc_nack_i : data_nack_i;

  always_comb begin
    ack_d = ack_q;
    if (ev_i) begin
      ack_d = fault | pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b1;
    end else if (ev_i) begin
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= ev_i;
    end
  end

  assign ack_o = ack_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/bcack_ctrl.sv
module bcack_ctrl
  import bcack_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int ERR_W      = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_match_i,
  input  logic              byte_rx_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              xfer_end_i,
  input  logic              hold_i,
  input  logic              data_nack_i,
  input  logic              eoc_nack_i,
  input  logic              autoload_en_i,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic [ERR_W-1:0]  err_flags_i,
  output logic              ack_o,
  output logic              ack_vld_o,
  output logic              cnt_zero_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              eop_o
);

  logic             rst_int_n;
  bc_state_e        state;
  logic             load_ev;
  logic             data_ev;
  logic             addr_ev;
  logic             at_end;
  logic             wr_ok;
  logic             ack_ev;
  logic             use_eoc;
  logic [CNT_W-1:0] load_val;

  // reset: asserted at once, released through a synchronizer
  generate
    if (RST_STAGES <= 1) begin : g_rst1
      logic rst_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_q <= 1'b0;
        end else begin
          rst_q <= 1'b1;
        end
      end
      assign rst_int_n = rst_q;
    end else begin : g_rstn
      logic [RST_STAGES-1:0] rst_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_pipe <= '0;
        end else begin
          rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
        end
      end
      assign rst_int_n = rst_pipe[RST_STAGES-1];
    end
  endgenerate

  // width adaptation of the length byte
  generate
    if (CNT_W > DATA_W) begin : g_ld_wide
      assign load_val = {{(CNT_W-DATA_W){1'b0}}, byte_data_i};
    end else if (CNT_W == DATA_W) begin : g_ld_same
      assign load_val = byte_data_i;
    end else begin : g_ld_narrow
      assign load_val = byte_data_i[CNT_W-1:0];
    end
  endgenerate

  bcack_seq i_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .addr_match_i  (addr_match_i),
    .byte_rx_i     (byte_rx_i),
    .xfer_end_i    (xfer_end_i),
    .autoload_en_i (autoload_en_i),
    .state_o       (state),
    .load_ev_o     (load_ev),
    .data_ev_o     (data_ev),
    .addr_ev_o     (addr_ev)
  );

  assign wr_ok = (state == ST_IDLE) || hold_i;

  bcack_counter #(
    .CNT_W (CNT_W)
  ) i_counter (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load_ev),
    .load_val_i (load_val),
    .dec_i      (data_ev),
    .wr_i       (cnt_wr_i),
    .wr_ok_i    (wr_ok),
    .wr_val_i   (cnt_wdata_i),
    .cnt_o      (cnt_o),
    .zero_o     (cnt_zero_o),
    .at_end_o   (at_end),
    .eop_o      (eop_o)
  );

  assign ack_ev  = addr_ev || load_ev || data_ev;
  assign use_eoc = data_ev && at_end;

  bcack_ack_sel #(
    .ERR_W (ERR_W)
  ) i_ack_sel (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ev_i        (ack_ev),
    .use_eoc_i   (use_eoc),
    .data_nack_i (data_nack_i),
    .eoc_nack_i  (eoc_nack_i),
    .err_i       (err_flags_i),
    .ack_o       (ack_o),
    .vld_o       (ack_vld_o)
  );

endmodule

// File: rtl/bcack_chk.sv
module bcack_chk #(
  parameter int CNT_W = 8,
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_match_i,
  input logic             byte_rx_i,
  input logic             cnt_wr_i,
  input logic             eoc_nack_i,
  input logic [ERR_W-1:0] err_flags_i,
  input logic             ack_o,
  input logic             ack_vld_o,
  input logic             cnt_zero_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             eop_o
);

  // R4
  err_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o && $past(|err_flags_i) |-> ack_o);

  // R9
  eop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> cnt_zero_o);

  // R9
  eop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> !eop_o);

  // R6
  addr_nodec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr_match_i) && !$past(cnt_wr_i) |-> cnt_o == $past(cnt_o));

  // R8
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_rx_i) && !$past(cnt_wr_i) |-> cnt_o == $past(cnt_o));

  // R1
  vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> $past(addr_match_i || byte_rx_i));

  // R3
  eoc_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o && eop_o && !$past(|err_flags_i) |-> ack_o == $past(eoc_nack_i));

endmodule

bind bcack_ctrl bcack_chk #(
  .CNT_W (CNT_W),
  .ERR_W (ERR_W)
) i_bcack_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_match_i (addr_match_i),
  .byte_rx_i    (byte_rx_i),
  .cnt_wr_i     (cnt_wr_i),
  .eoc_nack_i   (eoc_nack_i),
  .err_flags_i  (err_flags_i),
  .ack_o        (ack_o),
  .ack_vld_o    (ack_vld_o),
  .cnt_zero_o   (cnt_zero_o),
  .cnt_o        (cnt_o),
  .eop_o        (eop_o)
);

// File: tb/test_bcack_ctrl.sv
module test_bcack_ctrl;

  localparam int DW = 8;
  localparam int CW = 8;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          addr_match_i;
  logic          byte_rx_i;
  logic [DW-1:0] byte_data_i;
  logic          xfer_end_i;
  logic          hold_i;
  logic          data_nack_i;
  logic          eoc_nack_i;
  logic          autoload_en_i;
  logic          cnt_wr_i;
  logic [CW-1:0] cnt_wdata_i;
  logic [EW-1:0] err_flags_i;
  logic          ack_o;
  logic          ack_vld_o;
  logic          cnt_zero_o;
  logic [CW-1:0] cnt_o;
  logic          eop_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bcack_ctrl #(.DATA_W(DW), .CNT_W(CW), .ERR_W(EW)) i_bcack_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_match_i(addr_match_i), .byte_rx_i(byte_rx_i),
    .byte_data_i(byte_data_i), .xfer_end_i(xfer_end_i), .hold_i(hold_i),
    .data_nack_i(data_nack_i), .eoc_nack_i(eoc_nack_i), .autoload_en_i(autoload_en_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .err_flags_i(err_flags_i),
    .ack_o(ack_o), .ack_vld_o(ack_vld_o), .cnt_zero_o(cnt_zero_o), .cnt_o(cnt_o),
    .eop_o(eop_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic end_xfer();
    @(negedge clk);
    xfer_end_i = 1'b1;
    @(negedge clk);
    xfer_end_i = 1'b0;
  endtask

  task automatic write_cnt(input int v, input string tag, input int exp_cnt);
    @(negedge clk);
    cnt_wr_i    = 1'b1;
    cnt_wdata_i = CW'(v);
    @(negedge clk);
    cnt_wr_i = 1'b0;
    chk(tag, int'(cnt_o), exp_cnt);
  endtask

  task automatic send_addr(input int exp_ack, input int exp_cnt);
    @(negedge clk);
    addr_match_i = 1'b1;
    @(negedge clk);
    addr_match_i = 1'b0;
    chk("R1 addr vld", int'(ack_vld_o), 1);
    chk("R1 addr ack", int'(ack_o), exp_ack);
    chk("R6 addr cnt", int'(cnt_o), exp_cnt);
  endtask

  task automatic send_byte(input int d, input int exp_ack, input int exp_cnt,
                           input int exp_eop, input string tag);
    @(negedge clk);
    byte_rx_i   = 1'b1;
    byte_data_i = DW'(d);
    @(negedge clk);
    byte_rx_i = 1'b0;
    chk({tag, " vld"}, int'(ack_vld_o), 1);
    chk({tag, " ack"}, int'(ack_o), exp_ack);
    chk({tag, " cnt"}, int'(cnt_o), exp_cnt);
    chk({tag, " eop"}, int'(eop_o), exp_eop);
    chk({tag, " zero"}, int'(cnt_zero_o), int'(exp_cnt == 0));
    @(negedge clk);
    chk("R9 eop one cycle", int'(eop_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    addr_match_i = 1'b0; byte_rx_i = 1'b0; byte_data_i = '0; xfer_end_i = 1'b0;
    hold_i = 1'b0; data_nack_i = 1'b0; eoc_nack_i = 1'b0; autoload_en_i = 1'b0;
    cnt_wr_i = 1'b0; cnt_wdata_i = '0; err_flags_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk("R12 cnt", int'(cnt_o), 0);
    chk("R12 zero", int'(cnt_zero_o), 1);
    chk("R12 ack", int'(ack_o), 1);
    chk("R12 vld", int'(ack_vld_o), 0);
    chk("R12 eop", int'(eop_o), 0);

    // sweep: autoload, count, settings
    for (int al = 0; al < 2; al++) begin
      for (int n = 0; n < 5; n++) begin
        for (int s = 0; s < 4; s++) begin
          int dn;
          int en;
          dn = s & 1;
          en = (s >> 1) & 1;
          data_nack_i   = dn[0];
          eoc_nack_i    = en[0];
          autoload_en_i = al[0];
          end_xfer();
          write_cnt(al ? 0 : n, "R10 idle write", al ? 0 : n);
          send_addr(dn, al ? 0 : n);
          if (al == 1) begin
            send_byte(n, dn, n, 0, "R5 load");
          end
          for (int k = 1; k <= n + 1; k++) begin
            int rem;
            rem = n - k;
            if (rem > 0) begin
              send_byte(k, dn, rem, 0, "R2 data");
            end else begin
              send_byte(k, en, 0, int'(rem == 0), "R3 R8 R9 end");
            end
          end
        end
      end
    end

    // R4 error flags override both settings
    data_nack_i = 1'b0; eoc_nack_i = 1'b0; autoload_en_i = 1'b0;
    for (int e = 0; e < EW; e++) begin
      end_xfer();
      write_cnt(3, "R10 idle write", 3);
      err_flags_i = EW'(1) << e;
      send_addr(1, 3);
      send_byte(8'h11, 1, 2, 0, "R4 err data");
      err_flags_i = '0;
      send_byte(8'h12, 0, 1, 0, "R4 clear data");
      err_flags_i = EW'(1) << e;
      send_byte(8'h13, 1, 0, 1, "R4 err end");
      err_flags_i = '0;
    end

    // R7 settings changed after the event do not alter the answer
    end_xfer();
    write_cnt(4, "R10 idle write", 4);
    send_addr(0, 4);
    data_nack_i = 1'b1;
    repeat (2) idle_cycle();
    chk("R7 held ack", int'(ack_o), 0);
    send_byte(8'h21, 1, 3, 0, "R7 new setting");
    data_nack_i = 1'b0;
    idle_cycle();
    chk("R7 held nack", int'(ack_o), 1);

    // R10 write in data phase without hold is ignored, with hold accepted
    write_cnt(7, "R10 busy write ignored", 3);
    hold_i = 1'b1;
    write_cnt(7, "R10 held write", 7);
    hold_i = 1'b0;
    // R10 write in the same cycle as a counted byte is ignored
    @(negedge clk);
    hold_i = 1'b1; cnt_wr_i = 1'b1; cnt_wdata_i = 8'd50;
    byte_rx_i = 1'b1; byte_data_i = 8'h31;
    @(negedge clk);
    hold_i = 1'b0; cnt_wr_i = 1'b0; byte_rx_i = 1'b0;
    chk("R10 byte beats write", int'(cnt_o), 6);

    // R11 bytes in idle are ignored
    end_xfer();
    @(negedge clk);
    byte_rx_i = 1'b1; byte_data_i = 8'h44;
    @(negedge clk);
    byte_rx_i = 1'b0;
    chk("R11 idle no vld", int'(ack_vld_o), 0);
    chk("R11 idle cnt", int'(cnt_o), 6);

    // R5 large length byte with autoload, then decrement
    autoload_en_i = 1'b1;
    send_addr(0, 6);
    send_byte(200, 0, 200, 0, "R5 load big");
    send_byte(1, 0, 199, 0, "R8 step");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule